// File: doc/BRIEF.md
# Logic, Shift and Compare Execution Unit

This unit carries out the two-register bitwise, shift and rotate operations and the relational compares of a small 16-bit processor core. Each cycle the issue stage presents two operands, a group select and a 3-bit sub-opcode. A logic-group operation produces a registered result for the destination register, along with a one-cycle write strobe.

A compare-group operation writes no general register. Instead it sets a persistent one-bit truth flag, which later instructions read to decide whether they execute. Work happens on a rising clock edge only when the execute-enable input is high. The reset is synchronous and active high.

Top module: `lsc_unit`

## Requirements
- R1: With `rst` high at a rising edge, `dest_q`, `truth_q` and `dest_wr` become 0 at that edge.
- R2: With `exec_en` low at a rising edge, `dest_q` and `truth_q` keep their values and `dest_wr` is 0 after that edge.
- R3: Logic group (`grp_cmp`=0) codes 0, 1 and 2 load `dest_q` with `opnd_a` AND, OR and XOR `opnd_b` respectively.
- R4: Logic code 3 loads `dest_q` with the bitwise complement of `opnd_b`.
- R5: Logic code 4 shifts `opnd_a` left and code 5 shifts it right, filling with zeros; the amount is `opnd_b[3:0]`.
- R6: Logic code 6 rotates `opnd_a` right and code 7 rotates it left by `opnd_b[3:0]` places.
- R7: Compare group (`grp_cmp`=1) codes 0 to 5 load `truth_q` with unsigned a>b, a>=b, a<b, a<=b, a==b and a!=b respectively.
- R8: Compare codes 6 and 7 leave `truth_q` unchanged.
- R9: An executed compare leaves `dest_q` unchanged and `dest_wr` 0 after the edge.
- R10: An executed logic operation leaves `truth_q` unchanged, so the flag persists until the next valid compare.
- R11: `dest_wr` is 1 for exactly the cycle following an edge at which a logic operation executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute enable for the current operation |
| grp_cmp | input | 1 | Group select: 0 logic/shift, 1 compare |
| sub_op | input | 3 | Operation code within the group |
| opnd_a | input | 16 | First register operand |
| opnd_b | input | 16 | Second register operand / shift amount |
| dest_q | output | 16 | Registered destination result |
| dest_wr | output | 1 | Destination write strobe |
| truth_q | output | 1 | Truth flag for conditional execution |

## Verification
The bench builds the unit at its default 16-bit width, which gives a 4-bit shift amount. This makes amounts 0 and 15 reachable. It also exercises an operand whose bit 4 is set but must be ignored. Unsigned compares are checked with operand pairs whose top bit is set, where a signed reading would give the opposite result.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [2:0] {
        LOP_AND = 3'd0,
        LOP_OR  = 3'd1,
        LOP_XOR = 3'd2,
        LOP_NOT = 3'd3,
        LOP_SHL = 3'd4,
        LOP_SHR = 3'd5,
        LOP_ROR = 3'd6,
        LOP_ROL = 3'd7
    } logic_op_e;

    typedef enum logic [2:0] {
        REL_GT  = 3'd0,
        REL_GE  = 3'd1,
        REL_LT  = 3'd2,
        REL_LE  = 3'd3,
        REL_EQ  = 3'd4,
        REL_NE  = 3'd5,
        REL_RS6 = 3'd6,
        REL_RS7 = 3'd7
    } rel_op_e;

    typedef struct packed {
        logic valid;
        logic truth;
    } rel_res_t;

endpackage

// File: rtl/lsc_logic.sv
module lsc_logic #(
    parameter int DATA_W = 16
) (
    input  lsc_pkg::logic_op_e op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y
);
    import lsc_pkg::*;

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     amt;
    logic [2*DATA_W-1:0] dbl;
    logic [2*DATA_W-1:0] dbl_r;
    logic [2*DATA_W-1:0] dbl_l;

    assign amt   = b[SH_W-1:0];
    assign dbl   = {a, a};
    assign dbl_r = dbl >> amt;
    assign dbl_l = dbl << amt;

    always_comb begin
        unique case (op)
            LOP_AND: y = a & b;
            LOP_OR:  y = a | b;
            LOP_XOR: y = a ^ b;
            LOP_NOT: y = ~b;
            LOP_SHL: y = a << amt;
            LOP_SHR: y = a >> amt;
            LOP_ROR: y = dbl_r[DATA_W-1:0];
            LOP_ROL: y = dbl_l[2*DATA_W-1:DATA_W];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int DATA_W = 16
) (
    input  lsc_pkg::rel_op_e  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output lsc_pkg::rel_res_t res
);
    import lsc_pkg::*;

    logic gt, eq;

    assign gt = a > b;
    assign eq = a == b;

    always_comb begin
        res.valid = 1'b1;
        unique case (op)
            REL_GT:  res.truth = gt;
            REL_GE:  res.truth = gt | eq;
            REL_LT:  res.truth = ~(gt | eq);
            REL_LE:  res.truth = ~gt;
            REL_EQ:  res.truth = eq;
            REL_NE:  res.truth = ~eq;
            default: begin
                res.valid = 1'b0;
                res.truth = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lsc_unit.sv
module lsc_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic              grp_cmp,
    input  logic [2:0]        sub_op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] dest_q,
    output logic              dest_wr,
    output logic              truth_q
);
    import lsc_pkg::*;

    logic [DATA_W-1:0] logic_y;
    rel_res_t          rel;
    logic              do_logic;
    logic              do_cmp;

    assign do_logic = exec_en & ~grp_cmp;
    assign do_cmp   = exec_en & grp_cmp;

    lsc_logic #(.DATA_W(DATA_W)) logic_i (
        .op (logic_op_e'(sub_op)),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    lsc_compare #(.DATA_W(DATA_W)) cmp_i (
        .op  (rel_op_e'(sub_op)),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (rel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dest_q  <= '0;
            dest_wr <= 1'b0;
            truth_q <= 1'b0;
        end else begin
            dest_wr <= do_logic;
            if (do_logic) begin
                dest_q <= logic_y;
            end
            if (do_cmp && rel.valid) begin
                truth_q <= rel.truth;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dest_q == '0 && !truth_q && !dest_wr)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(exec_en)) |-> ($stable(dest_q) && $stable(truth_q) && !dest_wr)); // R2
    AST_RSVD_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(exec_en && grp_cmp && sub_op[2] && sub_op[1])) |-> $stable(truth_q)); // R8
    AST_CMP_NO_DEST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(exec_en && grp_cmp)) |-> ($stable(dest_q) && !dest_wr)); // R9
    AST_LOGIC_NO_TRUTH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(exec_en && !grp_cmp)) |-> ($stable(truth_q) && dest_wr)); // R10

endmodule

// File: tb/lsc_unit_tb_top.sv
module lsc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_en;
    logic        grp_cmp;
    logic [2:0]  sub_op;
    logic [15:0] opnd_a;
    logic [15:0] opnd_b;
    logic [15:0] dest_q;
    logic        dest_wr;
    logic        truth_q;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    lsc_unit #(.DATA_W(16)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .exec_en (exec_en),
        .grp_cmp (grp_cmp),
        .sub_op  (sub_op),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .dest_q  (dest_q),
        .dest_wr (dest_wr),
        .truth_q (truth_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rot1r(input logic [15:0] v);
        return {v[0], v[15:1]};
    endfunction

    function automatic logic [15:0] model_rot(input logic [15:0] v, input int n, input bit left);
        logic [15:0] r = v;
        for (int i = 0; i < n; i++) begin
            if (left) r = {r[14:0], r[15]};
            else      r = rot1r(r);
        end
        return r;
    endfunction

    function automatic logic model_rel(input int code, input logic [15:0] a, input logic [15:0] b);
        case (code)
            0: return a > b;
            1: return a >= b;
            2: return a < b;
            3: return a <= b;
            4: return a == b;
            default: return a != b;
        endcase
    endfunction

    // drive at negedge, one rising edge, sample at next negedge
    task automatic do_op(input logic g, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
        grp_cmp = g; sub_op = op; opnd_a = a; opnd_b = b; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; exec_en = 1'b0; grp_cmp = 1'b0; sub_op = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        chk("R1 dest_q", dest_q, 16'h0);
        chk("R1 truth_q", {15'b0, truth_q}, 16'h0);
        chk("R1 dest_wr", {15'b0, dest_wr}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_bitwise;
        do_op(1'b0, 3'd0, 16'hF0F0, 16'h3C3C); chk("R3 AND", dest_q, 16'h3030);
        chk("R11 dest_wr", {15'b0, dest_wr}, 16'h1);
        do_op(1'b0, 3'd1, 16'hF0F0, 16'h3C3C); chk("R3 OR", dest_q, 16'hFCFC);
        do_op(1'b0, 3'd2, 16'hF0F0, 16'h3C3C); chk("R3 XOR", dest_q, 16'hCCCC);
        do_op(1'b0, 3'd3, 16'h1234, 16'h00FF); chk("R4 NOT", dest_q, 16'hFF00);
        @(negedge clk);
        chk("R11 dest_wr drop", {15'b0, dest_wr}, 16'h0);
    endtask

    task automatic t_shift;
        do_op(1'b0, 3'd4, 16'h8001, 16'h0011); chk("R5 SHL amt low bits", dest_q, 16'h0002);
        do_op(1'b0, 3'd5, 16'h8001, 16'h0004); chk("R5 SHR 4", dest_q, 16'h0800);
        do_op(1'b0, 3'd4, 16'h0001, 16'h000F); chk("R5 SHL 15", dest_q, 16'h8000);
        do_op(1'b0, 3'd5, 16'hA5A5, 16'h0010); chk("R5 SHR 0", dest_q, 16'hA5A5);
    endtask

    task automatic t_rotate;
        for (int n = 0; n < 16; n += 5) begin
            do_op(1'b0, 3'd6, 16'h8001, 16'(n)); chk("R6 ROR", dest_q, model_rot(16'h8001, n, 1'b0));
            do_op(1'b0, 3'd7, 16'hC3A1, 16'(n)); chk("R6 ROL", dest_q, model_rot(16'hC3A1, n, 1'b1));
        end
    endtask

    task automatic t_compare;
        logic [15:0] pa [4] = '{16'h0005, 16'h0009, 16'h0007, 16'hFFFF};
        logic [15:0] pb [4] = '{16'h0009, 16'h0005, 16'h0007, 16'h0001};
        logic [15:0] held;
        do_op(1'b0, 3'd2, 16'h1357, 16'h0000);
        held = dest_q;
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 6; c++) begin
                do_op(1'b1, 3'(c), pa[p], pb[p]);
                chk("R7 relation", {15'b0, truth_q}, {15'b0, model_rel(c, pa[p], pb[p])});
            end
        end
        chk("R9 dest_q kept", dest_q, held);
        chk("R9 dest_wr", {15'b0, dest_wr}, 16'h0);
    endtask

    task automatic t_unused_and_persist;
        do_op(1'b1, 3'd4, 16'h0042, 16'h0042);
        do_op(1'b1, 3'd6, 16'h0001, 16'h0002); chk("R8 code6 keeps 1", {15'b0, truth_q}, 16'h1);
        do_op(1'b0, 3'd1, 16'h0000, 16'h0000); chk("R10 logic keeps 1", {15'b0, truth_q}, 16'h1);
        do_op(1'b1, 3'd5, 16'h0042, 16'h0042);
        do_op(1'b1, 3'd7, 16'h0001, 16'h0002); chk("R8 code7 keeps 0", {15'b0, truth_q}, 16'h0);
        do_op(1'b0, 3'd3, 16'h0000, 16'h0000); chk("R10 logic keeps 0", {15'b0, truth_q}, 16'h0);
    endtask

    task automatic t_disabled;
        logic [15:0] held;
        do_op(1'b1, 3'd4, 16'h0003, 16'h0003);
        do_op(1'b0, 3'd1, 16'h5A00, 16'h005A);
        held = dest_q;
        exec_en = 1'b0; grp_cmp = 1'b0; sub_op = 3'd3; opnd_b = 16'h0F0F;
        @(negedge clk);
        chk("R2 dest_q held logic", dest_q, held);
        chk("R2 dest_wr low", {15'b0, dest_wr}, 16'h0);
        grp_cmp = 1'b1; sub_op = 3'd5; opnd_a = 16'h0001; opnd_b = 16'h0002;
        repeat (2) @(negedge clk);
        chk("R2 truth held", {15'b0, truth_q}, 16'h1);
        chk("R2 dest_q held cmp", dest_q, held);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_bitwise();
        t_shift();
        t_rotate();
        t_compare();
        t_unused_and_persist();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule